// File: doc/BRIEF.md
# Semi-Carry-Save Radix-2 Montgomery Modular Multiplier

This block computes a Montgomery product of two K-bit operands against an odd K-bit modulus. It works one multiplier bit per clock and keeps its running sum as two vectors, a sum vector and a carry vector. A single one-level carry-save adder is shared by three phases of every operation. The first phase forms the constant D = B + N. The second phase is the main loop of K+2 iterations. The third phase turns the sum/carry pair back into a plain binary number. Both conversion phases feed the adder's outputs back into its inputs with a zero addend, and stop when a wide NOR reports that the carry vector has become zero.

Operands enter through a valid/ready handshake. `in_ready` is high only while the block is idle. An offer made while `in_ready` is low is not taken, so a source that wants its operands used must hold `in_valid` and the operands until it sees `in_ready` high at a clock edge. There is no back-pressure on the output side. `done` pulses for one cycle, and `result` keeps its value until the next operation is accepted. The result lies in [0, 2N) and is congruent to A·B·2^-(K+2) mod N. No final subtraction is made. K defaults to 128, and the bench uses a smaller width.

Top module: `semicarry_mont_mul`

## Requirements
- R1: After reset, `in_ready` is 1, `busy` is 0, `done` is 0 and `result` is 0.
- R2: Operands are captured only at a clock edge where `in_valid` and `in_ready` are both 1. While `busy` is 1, `in_ready` is 0, and offers made during that time do not change the result of the operation in progress.
- R3: For an odd modulus N and operands A, B < N, `result` mod N equals A·B·2^-(K+2) mod N. The exponent K+2 is the number of loop iterations, and A is consumed least significant bit first.
- R4: When `done` is 1, `result` is less than 2N. No carry leaves the top of the K+2-bit datapath during the two conversion phases.
- R5: `done` is high for exactly one cycle per operation. `result` holds its value from that cycle until the next accepted operation.
- R6: The main loop runs exactly K+2 iterations. With A = 0 and B = 0, `done` rises exactly K+4 clock edges after the accepting edge.
- R7: An operation ends no later than 3K+10 clock edges after the accepting edge, including operands whose sum B+N ripples a carry through every bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offer |
| in_ready | output | 1 | Block idle and able to take operands |
| a_in | input | K | Multiplier operand A |
| b_in | input | K | Multiplicand operand B |
| n_in | input | K | Odd modulus N |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | K+1 | Product in carry-resolved binary, below 2N |

## Verification
A table of fixed operands covers several cases: tiny moduli such as 1 and 3, the largest odd 16-bit modulus, and operands one below the modulus. These cases separate a wrong quotient-bit choice from a wrong addend choice, because each one drives a different mix of the four addend selections. Random odd moduli with random operands reach many loop paths. Pairs such as B = 1 with N = 0xFFFF force a carry to ripple through the whole width during precompute, and they show whether the zero-carry stop condition and the cycle bound hold. An all-zero operation pins the exact loop length. Offers made mid-operation show that captured operands cannot be overwritten.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LOOP,
    ST_CONV,
    ST_DONE
  } smm_state_e;
endpackage

// File: rtl/smm_csa.sv
module smm_csa #(
  parameter int W = 18
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] maj
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign s[g]   = x[g] ^ y[g] ^ z[g];
    assign maj[g] = (x[g] & y[g]) | (x[g] & z[g]) | (y[g] & z[g]);
  end
endmodule

// File: rtl/smm_addend.sv
module smm_addend #(
  parameter int W = 18
) (
  input  logic         a_bit,
  input  logic         ss_lsb,
  input  logic         sc_lsb,
  input  logic [W-1:0] b_val,
  input  logic [W-1:0] n_val,
  input  logic [W-1:0] d_val,
  output logic         q_bit,
  output logic [W-1:0] addend
);
  always_comb begin
    q_bit = ss_lsb ^ sc_lsb ^ (a_bit & b_val[0]);
    unique case ({a_bit, q_bit})
      2'b00:   addend = '0;
      2'b01:   addend = n_val;
      2'b10:   addend = b_val;
      default: addend = d_val;
    endcase
  end
endmodule

// File: rtl/smm_zero.sv
module smm_zero #(
  parameter int W = 18
) (
  input  logic [W-1:0] vec,
  output logic         is_zero
);
  assign is_zero = ~|vec;
endmodule

// File: rtl/semicarry_mont_mul.sv
module semicarry_mont_mul
  import smm_pkg::*;
#(
  parameter int K = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [K-1:0] a_in,
  input  logic [K-1:0] b_in,
  input  logic [K-1:0] n_in,
  output logic         busy,
  output logic         done,
  output logic [K:0]   result
);
  localparam int W  = K + 2;
  localparam int CW = $clog2(K + 2);
  localparam logic [CW-1:0] LAST_IT = CW'(K + 1);

  smm_state_e      state;
  logic [K-1:0]    a_r;
  logic [W-1:0]    b_r, n_r, d_r;
  logic [W-1:0]    ss, sc;
  logic [CW-1:0]   it_cnt;
  logic [W-1:0]    addend, csa_z, csa_s, csa_maj;
  logic            q_bit, sc_zero, accept;
  logic [W-1:0]    b_ext, n_ext;

  assign b_ext    = {2'b00, b_in};
  assign n_ext    = {2'b00, n_in};
  assign in_ready = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign accept   = in_valid && in_ready;
  assign csa_z    = (state == ST_LOOP) ? addend : '0;

  smm_addend #(.W(W)) u_addend (
    .a_bit (a_r[0]),
    .ss_lsb(ss[0]),
    .sc_lsb(sc[0]),
    .b_val (b_r),
    .n_val (n_r),
    .d_val (d_r),
    .q_bit (q_bit),
    .addend(addend)
  );

  smm_csa #(.W(W)) u_csa (
    .x  (ss),
    .y  (sc),
    .z  (csa_z),
    .s  (csa_s),
    .maj(csa_maj)
  );

  smm_zero #(.W(W)) u_zero (
    .vec    (sc),
    .is_zero(sc_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      a_r    <= '0;
      b_r    <= '0;
      n_r    <= '0;
      d_r    <= '0;
      ss     <= '0;
      sc     <= '0;
      it_cnt <= '0;
      result <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          a_r   <= a_in;
          b_r   <= b_ext;
          n_r   <= n_ext;
          ss    <= b_ext ^ n_ext;
          sc    <= {(b_ext[W-2:0] & n_ext[W-2:0]), 1'b0};
          state <= ST_PRE;
        end
        ST_PRE: if (sc_zero) begin
          d_r    <= ss;
          ss     <= '0;
          sc     <= '0;
          it_cnt <= '0;
          state  <= ST_LOOP;
        end else begin
          ss <= csa_s;
          sc <= {csa_maj[W-2:0], 1'b0};
        end
        ST_LOOP: begin
          ss     <= {1'b0, csa_s[W-1:1]};
          sc     <= csa_maj;
          a_r    <= {1'b0, a_r[K-1:1]};
          it_cnt <= it_cnt + 1'b1;
          if (it_cnt == LAST_IT) state <= ST_CONV;
        end
        ST_CONV: if (sc_zero) begin
          result <= ss[K:0];
          state  <= ST_DONE;
        end else begin
          ss <= csa_s;
          sc <= {csa_maj[W-2:0], 1'b0};
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Loop step must leave an even sum so the halving drops nothing.
  AST_LOOP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOP) |-> (csa_s[0] == 1'b0)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRE || state == ST_CONV) |-> !csa_maj[W-1]); // R4

  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < {n_r[K-1:0], 1'b0})); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE || (state == ST_IDLE && !in_valid)) |=> $stable(result)); // R5

  AST_LOOP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOP && it_cnt == LAST_IT) |=> (state == ST_CONV)); // R6

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != ST_DONE) |=> busy); // R2
endmodule

// File: tb/semicarry_mont_mul_test.sv
`timescale 1ns/1ps
module semicarry_mont_mul_test;
  localparam int K = 16;
  localparam int NV = 9;
  // each entry: {N, A, B}
  localparam logic [47:0] VEC [NV] = '{
    {16'd65521, 16'd12345, 16'd54321},
    {16'd65535, 16'd65534, 16'd65534},
    {16'd3,     16'd2,     16'd2},
    {16'd1,     16'd0,     16'd0},
    {16'd40961, 16'd1,     16'd1},
    {16'd65535, 16'd65534, 16'd1},
    {16'd32769, 16'd32768, 16'd32767},
    {16'd257,   16'd256,   16'd255},
    {16'd65533, 16'd40000, 16'd30000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, busy, done;
  logic [K-1:0] a_in = '0, b_in = '0, n_in = '0;
  logic [K:0] result;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  semicarry_mont_mul #(.K(K)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_in(a_in), .b_in(b_in), .n_in(n_in), .busy(busy), .done(done),
    .result(result)
  );

  always #4 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint ref_mont(input longint a, input longint b, input longint n);
    longint x;
    x = (a * b) % n;
    for (int i = 0; i < K + 2; i++) begin
      if (x[0]) x = (x + n) >> 1;
      else      x = x >> 1;
    end
    return x;
  endfunction

  task automatic run_op(input longint a, input longint b, input longint n,
                        input string tag, output int lat);
    longint expv;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    a_in = a[K-1:0]; b_in = b[K-1:0]; n_in = n[K-1:0]; in_valid = 1'b1;
    @(posedge clk);
    lat = 0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      in_valid = 1'b0;
      if (done || lat > 2000) break;
    end
    expv = ref_mont(a, b, n);
    chk(longint'(result) % n == expv, {tag, " R3 value"}, longint'(result) % n, expv);
    chk(longint'(result) < 2 * n, {tag, " R4 range"}, longint'(result), 2 * n);
    chk(lat <= 3 * K + 10, {tag, " R7 latency bound"}, lat, 3 * K + 10);
  endtask

  initial begin
    int lat;
    longint held, nr, ar, br;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(result == '0, "R1 result", result, 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      run_op(VEC[i][31:16], VEC[i][15:0], VEC[i][47:32], "table", lat);
      // R5: done for one cycle only, result held afterwards
      held = result;
      @(negedge clk);
      chk(done == 1'b0, "R5 done pulse width", done, 0);
      chk(longint'(result) == held, "R5 result held", result, held);
    end

    // R6: all-zero operands give the minimum latency K+4
    run_op(0, 0, 65521, "zero", lat);
    chk(lat == K + 4, "R6 exact loop latency", lat, K + 4);

    // R7: carry ripples through full width in B+N
    run_op(7, 1, 65535, "ripple1", lat);
    run_op(1, 65534, 65535, "ripple2", lat);
    run_op(32767, 1, 32767, "ripple3", lat);

    // R2: offers during busy are refused and do not disturb the operation
    @(negedge clk);
    a_in = 16'd111; b_in = 16'd222; n_in = 16'd65521; in_valid = 1'b1;
    @(posedge clk);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      a_in = 16'd9999; b_in = 16'd8888; n_in = 16'd40961; in_valid = 1'b1;
      chk(in_ready == 1'b0, "R2 in_ready low while busy", in_ready, 0);
      chk(busy == 1'b1, "R2 busy during operation", busy, 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(longint'(result) % 65521 == ref_mont(111, 222, 65521), "R2 first operands kept",
        longint'(result) % 65521, ref_mont(111, 222, 65521));

    // R3: random odd moduli
    for (int t = 0; t < 20; t++) begin
      nr = longint'($urandom_range(65535, 3)) | 1;
      ar = longint'($urandom) % nr;
      br = longint'($urandom) % nr;
      run_op(ar, br, nr, "random", lat);
    end

    summary();
    $finish;
  end
endmodule